// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Hardware Address Filtering

This block recovers 8-bit or 9-bit asynchronous frames from a serial line. It is clocked by the system clock and advances on a 16x oversampling tick. Each bit is sampled three times around its centre, and the three samples are resolved by majority vote. A start bit that reads high at its centre is treated as noise and dropped. A missing stop bit sets a framing-error flag. That flag stays set until software clears it.

When multiprocessor filtering is enabled, the block compares each received byte with two addresses. It builds the first by ANDing its own-address register with a mask register, and the second by ORing the same two registers. A frame raises the receive-done flag only when it matches one of them and carries the marker that identifies an address frame. In 9-bit mode that marker is a ninth bit of 1. In 8-bit mode it is a valid stop bit. With filtering disabled, every complete frame is delivered. While the receive-done flag is still set, a new frame never overwrites the held data.

Top module: `mproc_uart_rx`

## Requirements
- R1: After reset rx_data, rx_bit9, rx_done and rx_ferr are all 0.
- R2: With mp_en low, a frame of one low start bit, eight data bits sent LSB first and a stop bit sets rx_done and presents the eight bits on rx_data. A 9-bit frame is delivered the same way.
- R3: When nine_bit is 1, the bit that follows the eight data bits is captured into rx_bit9. When nine_bit is 0, rx_bit9 takes the sampled stop bit.
- R4: Each bit is decided by majority vote over samples taken at ticks 7, 8 and 9 of its 16 ticks, so one wrong sample does not change the bit.
- R5: A start bit that votes high is rejected. No frame is delivered, and the receiver waits for the next falling edge.
- R6: A stop bit that votes low sets rx_ferr. Only a pulse on fe_clr clears rx_ferr, and later good frames do not clear it.
- R7: rx_done stays set until rd_clr is pulsed. A frame that completes while rx_done is set leaves rx_data and rx_bit9 unchanged.
- R8: With mp_en high and nine_bit high, a frame is delivered only if its ninth bit is 1 and its byte matches the given or broadcast address.
- R9: With mp_en high and nine_bit low, a frame is delivered only if its stop bit is valid and its byte matches the given or broadcast address.
- R10: The byte matches the given address when it equals own_addr in every position where addr_mask is 1. Positions where addr_mask is 0 are don't-care.
- R11: The byte matches the broadcast address when it has a 1 in every position where (own_addr OR addr_mask) is 1.
- R12: With own_addr and addr_mask both zero, every byte matches, so only the ninth-bit or stop-bit test remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| nine_bit | input | 1 | 1 selects 9-bit frames, 0 selects 8-bit frames |
| mp_en | input | 1 | Enables multiprocessor address filtering |
| own_addr | input | 8 | Own-address register |
| addr_mask | input | 8 | Address mask register |
| rd_clr | input | 1 | Pulse that clears rx_done |
| fe_clr | input | 1 | Pulse that clears rx_ferr |
| rx_data | output | 8 | Last delivered byte |
| rx_bit9 | output | 1 | Ninth bit, or the stop bit in 8-bit mode |
| rx_done | output | 1 | Frame delivered, waiting to be read |
| rx_ferr | output | 1 | Sticky framing-error flag |

## Verification
The bench builds the receiver with its default parameters: 16 ticks per bit, 8 data bits and a two-stage input synchronizer. It pulses baud_tick on every second clock, so one bit lasts 32 clocks and there are idle clocks between ticks. Two-clock glitches can then land on exactly one of the three vote samples, and a short low pulse can fall entirely before the centre of a start bit. The address tests use masks that make the given and broadcast matches differ in single bit positions, so a mistake in either compare changes which frames are delivered.

// File: rtl/mpu_rx_pkg.sv
package mpu_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_NINTH = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;

  // majority of three samples
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // masked compare: every bit where mask is 1 must equal own
  function automatic logic given_match(input logic [7:0] rx_byte,
                                       input logic [7:0] own,
                                       input logic [7:0] mask);
    return ((rx_byte ^ own) & mask) == 8'h00;
  endfunction

  // broadcast: every 1 of (own | mask) must be 1 in the byte
  function automatic logic bcast_match(input logic [7:0] rx_byte,
                                       input logic [7:0] own,
                                       input logic [7:0] mask);
    logic [7:0] need;
    need = own | mask;
    return (rx_byte & need) == need;
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import mpu_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line_s,
  input  logic              nine_bit,
  output logic              frame_end,
  output logic              stop_ok,
  output logic              start_drop,
  output logic [DATA_W-1:0] shift_q,
  output logic              ninth_q
);
  localparam int CW     = $clog2(OVS);
  localparam int IW     = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int SMP_LO = OVS/2 - 1;
  localparam int SMP_HI = OVS/2 + 1;

  rx_state_e       state;
  logic [CW-1:0]   cnt;
  logic [IW-1:0]   idx;
  logic [1:0]      vote;
  logic            in_window, decide, bit_end, bit_val;

  assign in_window = (cnt >= CW'(SMP_LO)) && (cnt < CW'(SMP_HI));
  assign decide    = tick && (state != ST_IDLE) && (cnt == CW'(SMP_HI));
  assign bit_end   = tick && (state != ST_IDLE) && (cnt == CW'(OVS-1));
  assign bit_val   = maj3(vote[1], vote[0], line_s);

  assign frame_end  = decide && (state == ST_STOP);
  assign stop_ok    = bit_val;
  assign start_drop = decide && (state == ST_START) && bit_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      vote    <= '0;
      shift_q <= '0;
      ninth_q <= 1'b0;
    end else if (tick) begin
      if (state == ST_IDLE) begin
        if (!line_s) begin
          state <= ST_START;
          cnt   <= CW'(1);
        end
      end else begin
        cnt <= (cnt == CW'(OVS-1)) ? '0 : cnt + CW'(1);
        if (in_window) vote <= {vote[0], line_s};
        if (decide) begin
          case (state)
            ST_START: if (bit_val) state <= ST_IDLE;
            ST_DATA:  shift_q <= {bit_val, shift_q[DATA_W-1:1]};
            ST_NINTH: ninth_q <= bit_val;
            ST_STOP:  state <= ST_IDLE;
            default:  ;
          endcase
        end
        if (bit_end) begin
          case (state)
            ST_START: begin
              state <= ST_DATA;
              idx   <= '0;
            end
            ST_DATA: begin
              if (idx == IW'(DATA_W-1)) state <= nine_bit ? ST_NINTH : ST_STOP;
              else                      idx   <= idx + IW'(1);
            end
            ST_NINTH: state <= ST_STOP;
            default:  ;
          endcase
        end
      end
    end
  end

  // R5: a noisy start returns the receiver to idle
  p_start_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_drop |=> (state == ST_IDLE));

  // R2: a frame only ends from the stop-bit state
  p_end_from_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (state == ST_IDLE));
endmodule

// File: rtl/rx_addr_match.sv
module rx_addr_match
  import mpu_rx_pkg::*;
(
  input  logic [7:0] rx_byte,
  input  logic [7:0] own_addr,
  input  logic [7:0] addr_mask,
  output logic       given_hit,
  output logic       bcast_hit,
  output logic       addr_hit
);
  assign given_hit = given_match(rx_byte, own_addr, addr_mask);
  assign bcast_hit = bcast_match(rx_byte, own_addr, addr_mask);
  assign addr_hit  = given_hit | bcast_hit;
endmodule

// File: rtl/mproc_uart_rx.sv
module mproc_uart_rx
  import mpu_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       baud_tick,
  input  logic       nine_bit,
  input  logic       mp_en,
  input  logic [7:0] own_addr,
  input  logic [7:0] addr_mask,
  input  logic       rd_clr,
  input  logic       fe_clr,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       rx_done,
  output logic       rx_ferr
);
  localparam int DATA_W = 8;

  logic              line_s;
  logic              frame_end, stop_ok, start_drop, ninth_q;
  logic [DATA_W-1:0] shift_q;
  logic              given_hit, bcast_hit, addr_hit;
  logic              marker_ok, accept;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s)
  );

  rx_frame_fsm #(.OVS(OVS), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .line_s(line_s),
    .nine_bit(nine_bit), .frame_end(frame_end), .stop_ok(stop_ok),
    .start_drop(start_drop), .shift_q(shift_q), .ninth_q(ninth_q)
  );

  rx_addr_match u_match (
    .rx_byte(shift_q), .own_addr(own_addr), .addr_mask(addr_mask),
    .given_hit(given_hit), .bcast_hit(bcast_hit), .addr_hit(addr_hit)
  );

  assign marker_ok = nine_bit ? ninth_q : stop_ok;
  assign accept    = frame_end && !rx_done && (!mp_en || (marker_ok && addr_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_bit9 <= 1'b0;
      rx_done <= 1'b0;
      rx_ferr <= 1'b0;
    end else begin
      if (accept) begin
        rx_data <= shift_q;
        rx_bit9 <= nine_bit ? ninth_q : stop_ok;
        rx_done <= 1'b1;
      end else if (rd_clr) begin
        rx_done <= 1'b0;
      end
      if (frame_end && !stop_ok) rx_ferr <= 1'b1;
      else if (fe_clr)           rx_ferr <= 1'b0;
    end
  end

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !rd_clr |=> rx_done);

  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> $stable(rx_data) && $stable(rx_bit9));

  p_fe_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ferr && !fe_clr |=> rx_ferr);

  p_fe_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && !stop_ok |=> rx_ferr);

  p_mp9_marker_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && mp_en && nine_bit |=> rx_bit9);

  p_mp_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept && mp_en |-> (given_hit || bcast_hit));

  p_mp8_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && mp_en && !nine_bit |-> stop_ok);

  p_no_frame_on_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_drop |-> !frame_end);
endmodule

// File: tb/tb_mproc_uart_rx.sv
module tb_mproc_uart_rx;
  localparam int BIT_CYC = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       baud_tick = 1'b0;
  logic       nine_bit = 1'b0;
  logic       mp_en = 1'b0;
  logic [7:0] own_addr = 8'h00;
  logic [7:0] addr_mask = 8'h00;
  logic       rd_clr = 1'b0;
  logic       fe_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit9, rx_done, rx_ferr;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  always @(posedge clk) baud_tick <= rst_n ? ~baud_tick : 1'b0;

  mproc_uart_rx dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_tick(baud_tick),
    .nine_bit(nine_bit), .mp_en(mp_en), .own_addr(own_addr),
    .addr_mask(addr_mask), .rd_clr(rd_clr), .fe_clr(fe_clr),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_done(rx_done), .rx_ferr(rx_ferr)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // independent address model, bit by bit
  function automatic bit model_hit(input logic [7:0] b, input logic [7:0] own,
                                   input logic [7:0] msk);
    bit g = 1'b1;
    bit c = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (msk[i] && (b[i] != own[i])) g = 1'b0;
      if ((own[i] || msk[i]) && !b[i]) c = 1'b0;
    end
    return g || c;
  endfunction

  task automatic drive_bit(input logic v, input int glitch);
    for (int c = 0; c < BIT_CYC; c++) begin
      @(negedge clk);
      rx_line = (glitch != 0 && (c == 16 || c == 17)) ? ~v : v;
    end
  endtask

  // glitch_pos: -1 none, 0..7 data bit index
  task automatic send(input logic [7:0] b, input logic b9, input logic stop_v,
                      input int glitch_pos);
    drive_bit(1'b0, 0);
    for (int i = 0; i < 8; i++) drive_bit(b[i], (glitch_pos == i) ? 1 : 0);
    if (nine_bit) drive_bit(b9, 0);
    drive_bit(stop_v, 0);
    rx_line = 1'b1;
    repeat (BIT_CYC) @(negedge clk);
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd_clr = 1'b1;
    @(negedge clk); rd_clr = 1'b0;
  endtask

  task automatic pulse_fe();
    @(negedge clk); fe_clr = 1'b1;
    @(negedge clk); fe_clr = 1'b0;
  endtask

  task automatic t_reset();
    check(rx_data == 8'h00, "R1 rx_data", rx_data, 0);
    check(rx_bit9 == 1'b0, "R1 rx_bit9", rx_bit9, 0);
    check(rx_done == 1'b0, "R1 rx_done", rx_done, 0);
    check(rx_ferr == 1'b0, "R1 rx_ferr", rx_ferr, 0);
  endtask

  task automatic t_plain();
    nine_bit = 1'b0; mp_en = 1'b0;
    send(8'hA5, 1'b0, 1'b1, -1);
    check(rx_done == 1'b1, "R2 done 8-bit", rx_done, 1);
    check(rx_data == 8'hA5, "R2 data 8-bit", rx_data, 8'hA5);
    check(rx_bit9 == 1'b1, "R3 stop in bit9", rx_bit9, 1);
    pulse_rd();
    check(rx_done == 1'b0, "R7 rd_clr clears", rx_done, 0);
    nine_bit = 1'b1;
    send(8'h3C, 1'b0, 1'b1, -1);
    check(rx_data == 8'h3C && rx_done, "R2 data 9-bit", rx_data, 8'h3C);
    check(rx_bit9 == 1'b0, "R3 ninth=0", rx_bit9, 0);
    pulse_rd();
    send(8'h81, 1'b1, 1'b1, -1);
    check(rx_bit9 == 1'b1 && rx_data == 8'h81, "R3 ninth=1", {rx_bit9, rx_data}, 9'h181);
    pulse_rd();
    nine_bit = 1'b0;
  endtask

  task automatic t_glitch();
    send(8'h55, 1'b0, 1'b1, 3);
    check(rx_data == 8'h55 && rx_done, "R4 vote masks glitch", rx_data, 8'h55);
    pulse_rd();
    send(8'h00, 1'b0, 1'b1, 6);
    check(rx_data == 8'h00 && rx_done, "R4 vote masks glitch low", rx_data, 0);
    pulse_rd();
  endtask

  task automatic t_noise();
    repeat (3) @(negedge clk);
    rx_line = 1'b0;
    repeat (6) @(negedge clk);
    rx_line = 1'b1;
    repeat (12 * BIT_CYC) @(negedge clk);
    check(rx_done == 1'b0, "R5 noise start dropped", rx_done, 0);
    check(rx_ferr == 1'b0, "R5 no error from noise", rx_ferr, 0);
    send(8'h6B, 1'b0, 1'b1, -1);
    check(rx_data == 8'h6B && rx_done, "R5 next frame ok", rx_data, 8'h6B);
    pulse_rd();
  endtask

  task automatic t_ferr();
    send(8'h44, 1'b0, 1'b0, -1);
    check(rx_ferr == 1'b1, "R6 missing stop", rx_ferr, 1);
    pulse_rd();
    send(8'h45, 1'b0, 1'b1, -1);
    check(rx_ferr == 1'b1, "R6 sticky after good frame", rx_ferr, 1);
    pulse_rd();
    pulse_fe();
    check(rx_ferr == 1'b0, "R6 fe_clr clears", rx_ferr, 0);
  endtask

  task automatic t_hold();
    send(8'h11, 1'b0, 1'b1, -1);
    send(8'h22, 1'b0, 1'b1, -1);
    check(rx_data == 8'h11, "R7 no overwrite", rx_data, 8'h11);
    check(rx_done == 1'b1, "R7 done held", rx_done, 1);
    pulse_rd();
  endtask

  task automatic mp_try(input logic [7:0] b, input logic b9, input logic stop_v,
                        input string tag);
    logic exp_acc;
    logic marker;
    marker  = nine_bit ? b9 : stop_v;
    exp_acc = marker && model_hit(b, own_addr, addr_mask);
    send(b, b9, stop_v, -1);
    check(rx_done == exp_acc, tag, rx_done, exp_acc);
    if (exp_acc) check(rx_data == b, tag, rx_data, b);
    pulse_rd();
    pulse_fe();
  endtask

  task automatic t_mp9();
    nine_bit = 1'b1; mp_en = 1'b1;
    own_addr = 8'hC0; addr_mask = 8'hFD;
    mp_try(8'hC2, 1'b1, 1'b1, "R10 given hit");
    mp_try(8'hC1, 1'b1, 1'b1, "R10 given miss");
    mp_try(8'hC8, 1'b1, 1'b1, "R10 masked bit mismatch");
    mp_try(8'hC0, 1'b0, 1'b1, "R8 data frame filtered");
    mp_try(8'hFF, 1'b1, 1'b1, "R11 broadcast hit");
    mp_try(8'hFD, 1'b1, 1'b1, "R11 broadcast exact");
    own_addr = 8'h00; addr_mask = 8'h00;
    mp_try(8'h5A, 1'b1, 1'b1, "R12 zero regs match");
    mp_try(8'h5A, 1'b0, 1'b1, "R12 ninth still needed");
  endtask

  task automatic t_mp8();
    nine_bit = 1'b0; mp_en = 1'b1;
    own_addr = 8'h12; addr_mask = 8'hFF;
    mp_try(8'h12, 1'b0, 1'b1, "R9 match valid stop");
    mp_try(8'h12, 1'b0, 1'b0, "R9 bad stop rejected");
    mp_try(8'h13, 1'b0, 1'b1, "R9 address miss");
    mp_en = 1'b0;
    send(8'h13, 1'b0, 1'b1, -1);
    check(rx_done == 1'b1 && rx_data == 8'h13, "R2 filter off delivers", rx_data, 8'h13);
    pulse_rd();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_plain();
    t_glitch();
    t_noise();
    t_ferr();
    t_hold();
    t_mp9();
    t_mp8();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule